// File: doc/BRIEF.md
# Sync Output Formatter with Coast

This block rebuilds clean horizontal and vertical sync outputs in the pixel clock domain. It takes its line timing from a one-cycle lock-edge strobe and a known pixels-per-line count. It produces two horizontal pulses of programmable width:

- `hsyncout` always starts at the lock edge.
- `hsout` can instead be placed so that it ends on the lock edge. To do this the block starts the pulse width-minus-one pixels ahead of the predicted next strobe.

Vertical sync comes either from an internal integrator or from an external pin. It is either passed through raw or realigned so that it changes only at the start of a horizontal pulse.

The block also builds a coast window. The window covers the vertical sync lines, a programmable number of lines before vertical sync (taken from the end of the frame) and a programmable number of lines after it, together with an external coast input of selectable sense. An 8-bit control byte chooses the output modes and can three-state all four outputs. The control byte is captured only at a lock edge, so a mode change never cuts a line in two. The block drives each output as a data bit plus an enable, and the pad ring does the three-stating.

Top module: `sync_out_fmt`

## Requirements
- R1: While reset is active and until the first lock strobe, hsout, hsyncout, vsout and vsyncout are 0 and all four output enables are 1.
- R2: Control bit 0 = 1 drives all four output enables to 0; bit 0 = 0 drives them to 1. No control byte change has any effect on the outputs until the cycle after a lock strobe, in which the byte sampled in the strobe cycle applies.
- R3: hsyncout is 1 for exactly W cycles, beginning the cycle after each lock strobe, where W is hs_width, with hs_width = 0 treated as W = 1.
- R4: With control bit 2 = 1, hsout has the same leading-anchored waveform as hsyncout.
- R5: With control bit 2 = 0 and strobes every line_len cycles (W < line_len), hsout is 1 for the W cycles ending with the lock strobe cycle, and it is 0 in the cycle after each strobe.
- R6: With control bit 4 = 0, vsyncout takes the selected vertical sync value sampled in the strobe cycle, from the next cycle on, and holds it between strobes. With bit 4 = 1, vsyncout follows the selected vertical sync one cycle later.
- R7: vs_src_ext = 1 selects vs_ext as the vertical sync source; 0 selects vs_raw.
- R8: With control bit 7 = 0, vsout carries the strobe-aligned vertical sync of R6 (bit 4 = 0 form) regardless of bit 4.
- R9: With control bit 7 = 1, vsout carries coast, which is 1 on every line whose strobe sampled vertical sync as 1.
- R10: Coast also covers the post_coast lines that follow the last vertical sync line.
- R11: Lines are numbered from 0 at the first line that samples vertical sync high. When pre_coast > 0, coast also covers lines numbered frame_lines − pre_coast and above.
- R12: Control bits 3, 5 and 6 are reserved: they are treated as 0 and setting them changes no output.
- R13: Control bit 1 sets the coast input sense: 0 means coast_ext is active high, 1 means active low. The active coast input is ORed into coast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_stb | input | 1 | One-cycle strobe at each horizontal lock edge |
| line_len | input | PIXW | Pixels per line (strobe spacing) |
| hs_width | input | 8 | Horizontal output pulse width, 0 treated as 1 |
| vs_raw | input | 1 | Vertical sync from the integrator |
| vs_ext | input | 1 | Vertical sync from the external pin |
| vs_src_ext | input | 1 | 1 selects vs_ext, 0 selects vs_raw |
| coast_ext | input | 1 | External coast input |
| ctrl | input | 8 | Control byte |
| frame_lines | input | LINEW | Lines per frame |
| pre_coast | input | 8 | Lines of coast before vertical sync |
| post_coast | input | 8 | Lines of coast after vertical sync |
| hsout | output | 1 | Horizontal output, leading or trailing anchored |
| hsout_oe | output | 1 | Output enable for hsout |
| vsout | output | 1 | Aligned vertical sync or coast |
| vsout_oe | output | 1 | Output enable for vsout |
| hsyncout | output | 1 | Leading-anchored horizontal sync |
| hsyncout_oe | output | 1 | Output enable for hsyncout |
| vsyncout | output | 1 | Aligned or raw vertical sync |
| vsyncout_oe | output | 1 | Output enable for vsyncout |

## Verification
The bench uses the default widths (PIXW = 12, LINEW = 11) and drives a 16-pixel line with an 8-line frame. With lines this short, whole-line waveforms of both hsout anchorings can be compared pixel by pixel, including widths 1, 3 and 0. With a frame this short, two full frames with pre_coast = 2 and post_coast = 1 show where coast begins and ends at both ends of vertical sync. The bench also changes the control byte and vertical sync in the middle of a line, which exposes any effect that arrives before the next lock strobe.

// File: rtl/sync_out_fmt.sv
module sync_out_fmt #(
  parameter int PIXW  = 12,
  parameter int LINEW = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_stb,
  input  logic [PIXW-1:0]  line_len,
  input  logic [7:0]       hs_width,
  input  logic             vs_raw,
  input  logic             vs_ext,
  input  logic             vs_src_ext,
  input  logic             coast_ext,
  input  logic [7:0]       ctrl,
  input  logic [LINEW-1:0] frame_lines,
  input  logic [7:0]       pre_coast,
  input  logic [7:0]       post_coast,
  output logic             hsout,
  output logic             hsout_oe,
  output logic             vsout,
  output logic             vsout_oe,
  output logic             hsyncout,
  output logic             hsyncout_oe,
  output logic             vsyncout,
  output logic             vsyncout_oe
);

  localparam logic [7:0]       CTRL_MASK = 8'h97;
  localparam logic [PIXW-1:0]  PIX_MAX   = '1;
  localparam logic [PIXW-1:0]  PIX_ONE   = PIXW'(1);
  localparam logic [LINEW-1:0] LINE_MAX  = '1;
  localparam logic [LINEW-1:0] LINE_ONE  = LINEW'(1);

  logic [7:0]       ctrl_q, ctrl_n;
  logic [PIXW-1:0]  pix_q, pix_n;
  logic [LINEW-1:0] line_q, line_n;
  logic [7:0]       post_q, post_n;
  logic [PIXW:0]    wid;
  logic             run_q, run_n, vs_q, vs_n, vs_sel;
  logic             hs_lead_n, hs_trail_n, pre_hit, coast_n, oe_q;

  assign ctrl_n = lock_stb ? (ctrl & CTRL_MASK) : ctrl_q;
  assign pix_n  = lock_stb ? '0 : ((pix_q == PIX_MAX) ? pix_q : pix_q + PIX_ONE);
  assign run_n  = run_q | lock_stb;
  assign vs_sel = vs_src_ext ? vs_ext : vs_raw;
  assign vs_n   = lock_stb ? vs_sel : vs_q;
  assign wid    = (hs_width == 8'd0) ? (PIXW+1)'(1) : (PIXW+1)'(hs_width);

  assign hs_lead_n  = run_n & ({1'b0, pix_n} < wid);
  assign hs_trail_n = run_n & (({1'b0, pix_n} + wid) >= {1'b0, line_len});

  always_comb begin
    line_n = line_q;
    post_n = post_q;
    if (lock_stb) begin
      if (vs_sel && !vs_q)
        line_n = '0;
      else if (line_q != LINE_MAX)
        line_n = line_q + LINE_ONE;
      if (!vs_sel && vs_q)
        post_n = post_coast;
      else if (post_q != 8'd0)
        post_n = post_q - 8'd1;
    end
  end

  assign pre_hit = (pre_coast != 8'd0) &&
                   (({1'b0, line_n} + (LINEW+1)'(pre_coast)) >= {1'b0, frame_lines});
  assign coast_n = vs_n | (post_n != 8'd0) | pre_hit | (coast_ext ^ ctrl_n[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      pix_q    <= PIX_MAX;
      line_q   <= '0;
      post_q   <= '0;
      run_q    <= 1'b0;
      vs_q     <= 1'b0;
      hsout    <= 1'b0;
      hsyncout <= 1'b0;
      vsout    <= 1'b0;
      vsyncout <= 1'b0;
      oe_q     <= 1'b1;
    end else begin
      ctrl_q   <= ctrl_n;
      pix_q    <= pix_n;
      line_q   <= line_n;
      post_q   <= post_n;
      run_q    <= run_n;
      vs_q     <= vs_n;
      hsout    <= ctrl_n[2] ? hs_lead_n : hs_trail_n;
      hsyncout <= hs_lead_n;
      vsout    <= ctrl_n[7] ? coast_n : vs_n;
      vsyncout <= ctrl_n[4] ? vs_sel : vs_n;
      oe_q     <= ~ctrl_n[0];
    end
  end

  assign hsout_oe    = oe_q;
  assign vsout_oe    = oe_q;
  assign hsyncout_oe = oe_q;
  assign vsyncout_oe = oe_q;

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_stb |=> $stable(hsout_oe)); // R2
  AST_HSYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
    lock_stb |=> hsyncout); // R3
  AST_LEAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_stb && ctrl[2]) |=> hsout); // R4
  AST_TRAIL_END: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_stb && !ctrl[2] && (wid < {1'b0, line_len})) |=> !hsout); // R5
  AST_VS_ALIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_stb && !ctrl_q[4]) |=> $stable(vsyncout)); // R6

endmodule

// File: tb/sim_sync_out_fmt.sv
module sim_sync_out_fmt;
  localparam int L = 16;

  logic clk = 1'b0, rst_n = 1'b0, lock_stb = 1'b0;
  logic [11:0] line_len = 12'(L);
  logic [7:0] hs_width = 8'd3, ctrl = 8'd0, pre_coast = 8'd2, post_coast = 8'd1;
  logic [10:0] frame_lines = 11'd8;
  logic vs_raw = 1'b0, vs_ext = 1'b0, vs_src_ext = 1'b0, coast_ext = 1'b0;
  logic hsout, hsout_oe, vsout, vsout_oe, hsyncout, hsyncout_oe, vsyncout, vsyncout_oe;

  logic [15:0] w_hs, w_hy, w_vy, w_vo;
  logic [3:0]  w_oe [L];
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  sync_out_fmt #(.PIXW(12), .LINEW(11)) u0 (
    .clk(clk), .rst_n(rst_n), .lock_stb(lock_stb), .line_len(line_len),
    .hs_width(hs_width), .vs_raw(vs_raw), .vs_ext(vs_ext), .vs_src_ext(vs_src_ext),
    .coast_ext(coast_ext), .ctrl(ctrl), .frame_lines(frame_lines),
    .pre_coast(pre_coast), .post_coast(post_coast),
    .hsout(hsout), .hsout_oe(hsout_oe), .vsout(vsout), .vsout_oe(vsout_oe),
    .hsyncout(hsyncout), .hsyncout_oe(hsyncout_oe),
    .vsyncout(vsyncout), .vsyncout_oe(vsyncout_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat_lead(input int w);
    logic [15:0] p = '0;
    for (int k = 1; k <= w; k++) p[k] = 1'b1;
    return p;
  endfunction

  function automatic logic [15:0] pat_trail(input int w);
    logic [15:0] p = 16'h0001;
    for (int k = L - w + 1; k < L; k++) p[k] = 1'b1;
    return p;
  endfunction

  task automatic run_line(input bit mid_en, input bit mid_val);
    for (int k = 0; k < L; k++) begin
      @(negedge clk);
      w_hs[k] = hsout;
      w_hy[k] = hsyncout;
      w_vy[k] = vsyncout;
      w_vo[k] = vsout;
      w_oe[k] = {hsout_oe, vsout_oe, hsyncout_oe, vsyncout_oe};
      lock_stb = (k == 0);
      if (mid_en && k == 5) vs_raw = mid_val;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {hsout, vsout, hsyncout, vsyncout}, 4'h0);
    chk("R1 enables in reset", {hsout_oe, vsout_oe, hsyncout_oe, vsyncout_oe}, 4'hf);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 outputs before first strobe", {hsout, vsout, hsyncout, vsyncout}, 4'h0);
  endtask

  task automatic t_hsync();
    hs_width = 8'd3;
    run_line(0, 0); run_line(0, 0);
    chk("R3 hsyncout width 3", w_hy, pat_lead(3));
    hs_width = 8'd0;
    run_line(0, 0); run_line(0, 0);
    chk("R3 hsyncout width 0 as 1", w_hy, pat_lead(1));
    hs_width = 8'd3;
  endtask

  task automatic t_lead();
    ctrl = 8'h04;
    run_line(0, 0); run_line(0, 0);
    chk("R4 hsout leading anchored", w_hs, pat_lead(3));
  endtask

  task automatic t_trail();
    ctrl = 8'h00;
    run_line(0, 0); run_line(0, 0);
    chk("R5 hsout trailing width 3", w_hs, pat_trail(3));
    hs_width = 8'd1;
    run_line(0, 0); run_line(0, 0);
    chk("R5 hsout trailing width 1", w_hs, pat_trail(1));
    hs_width = 8'd3;
  endtask

  task automatic t_oe();
    ctrl = 8'h01;
    run_line(0, 0);
    chk("R2 no effect before strobe", w_oe[0], 4'hf);
    chk("R2 disabled after strobe", w_oe[1], 4'h0);
    chk("R2 disabled whole line", w_oe[L-1], 4'h0);
    ctrl = 8'h00;
    run_line(0, 0); run_line(0, 0);
    chk("R2 re-enabled", w_oe[1], 4'hf);
  endtask

  task automatic t_reserved();
    ctrl = 8'h68; vs_raw = 1'b0;
    run_line(0, 0); run_line(1, 1);
    chk("R12 reserved bits keep trailing hsout", w_hs, pat_trail(3));
    chk("R12 reserved bits keep enables", w_oe[3], 4'hf);
    chk("R12 reserved bits keep aligned vsyncout", w_vy, 16'h0000);
    run_line(0, 0);
    chk("R12 aligned vsyncout next line", w_vy, 16'hfffe);
    ctrl = 8'h00; vs_raw = 1'b0;
    run_line(0, 0); run_line(0, 0);
  endtask

  task automatic t_vs_aligned();
    run_line(1, 1);
    chk("R6 aligned vsyncout holds mid-line", w_vy, 16'h0000);
    run_line(0, 0);
    chk("R6 aligned vsyncout at strobe", w_vy, 16'hfffe);
    chk("R8 vsout aligned vsync", w_vo, 16'hfffe);
  endtask

  task automatic t_vs_raw();
    ctrl = 8'h10;
    run_line(0, 0); run_line(1, 0);
    chk("R6 raw vsyncout follows mid-line", w_vy, 16'h003f);
    chk("R8 vsout stays aligned in raw mode", w_vo, 16'hffff);
    ctrl = 8'h00;
    run_line(0, 0); run_line(0, 0);
  endtask

  task automatic t_vs_src();
    vs_src_ext = 1'b1; vs_ext = 1'b1; vs_raw = 1'b0;
    run_line(0, 0); run_line(0, 0);
    chk("R7 external vsync selected", w_vy, 16'hffff);
    vs_src_ext = 1'b0; vs_ext = 1'b0;
    run_line(0, 0); run_line(0, 0);
    chk("R7 integrator vsync selected", w_vy, 16'h0000);
  endtask

  task automatic t_coast();
    ctrl = 8'h80; coast_ext = 1'b0; pre_coast = 8'd2; post_coast = 8'd1;
    vs_raw = 1'b0;
    run_line(0, 0); run_line(0, 0);
    for (int f = 0; f < 2; f++) begin
      for (int j = 0; j < 8; j++) begin
        vs_raw = (j < 2);
        run_line(0, 0);
        if (j < 2)       chk("R9 coast on vsync line", w_vo[1], 1'b1);
        else if (j == 2) chk("R10 post-coast line", w_vo[1], 1'b1);
        else if (j >= 6) chk("R11 pre-coast line", w_vo[1], 1'b1);
        else             chk("R9 no coast mid-frame", w_vo[1], 1'b0);
      end
    end
  endtask

  task automatic t_polarity();
    pre_coast = 8'd0; post_coast = 8'd0; vs_raw = 1'b0; coast_ext = 1'b0;
    run_line(0, 0); run_line(0, 0);
    chk("R13 idle coast input high sense", w_vo[1], 1'b0);
    coast_ext = 1'b1;
    run_line(0, 0);
    chk("R13 active-high coast input", w_vo[1], 1'b1);
    ctrl = 8'h82;
    run_line(0, 0); run_line(0, 0);
    chk("R13 idle coast input low sense", w_vo[1], 1'b0);
    coast_ext = 1'b0;
    run_line(0, 0);
    chk("R13 active-low coast input", w_vo[1], 1'b1);
  endtask

  initial begin
    t_reset();
    t_hsync();
    t_lead();
    t_trail();
    t_oe();
    t_reserved();
    t_vs_aligned();
    t_vs_raw();
    t_vs_src();
    t_coast();
    t_polarity();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule